// File: doc/BRIEF.md
# Configurable UART Frame Engine

A serial transmitter and receiver pair whose frame layout is chosen at run time through a nine-bit control word. Software sets the start-bit line level, the stop-bit line level, the stop-bit count, an optional ninth bit, the bit order and optional RTS/CTS handshaking. The ninth bit carries either computed parity or a fixed value taken from the control word. A one-cycle tick at sixteen times the bit rate comes from a divider outside the block. Writing the data port queues a byte for transmission. Reading it returns the last byte that was received.

The transmitter state machine walks TX_IDLE → TX_START → TX_DATA → (TX_NINTH) → TX_STOP1 → (TX_STOP2) → TX_IDLE. It leaves TX_IDLE when a byte is pending and, with handshaking on, CTS is high. The receiver walks RX_IDLE → RX_START → RX_DATA → (RX_NINTH) → RX_STOP1 → (RX_STOP2) → RX_IDLE. In RX_START it either confirms the start bit at mid-bit or falls back to RX_IDLE. Every bit advances after sixteen ticks. The ninth-bit state is skipped when the ninth bit is off, and the second stop state is skipped with one stop bit. A flush command forces both machines to their idle state from any state.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset the control word reads 0x100 (stop level high, all else 0), tx rests high, rts is high, rx_err is 0 and the data port reads 0x00.
- R2: The idle tx line is the inverse of the start level (control bit 7). Each frame begins with one bit time at the start level.
- R3: Stop bits are driven at the stop level (control bit 8). Control bit 6 selects one stop bit (0) or two stop bits (1).
- R4: Each bit lasts 16 baud ticks. With control bit 3 clear, a frame is start, 8 data bits and stop bits, with no ninth bit.
- R5: With control bits 3 and 4 both set, a ninth bit follows the data. Control bit 5 = 1 gives even parity (total ones even) and control bit 5 = 0 gives odd parity.
- R6: With control bit 3 set and bit 4 clear, the ninth bit sent is control bit 5 itself. The receiver flags no error for any received ninth bit.
- R7: Control bit 2 selects LSB-first (0) or MSB-first (1) order for both directions.
- R8: With control bit 1 set, no frame starts while cts is low, and a pending byte starts once cts is high. With bit 1 clear, cts has no effect.
- R9: With control bit 1 set, rts is low from frame reception until the data port is read. With bit 1 clear, rts stays high.
- R10: Writing control bit 0 = 1 returns both directions to idle at once (tx at idle level, pending byte dropped, partial receive discarded). Bit 0 always reads back 0.
- R11: The receiver samples each bit near mid-bit. A completed frame replaces the byte read from the data port.
- R12: A start-level pulse that is gone by mid-bit is ignored: no byte is received.
- R13: A parity mismatch or a stop bit at the wrong level sets rx_err. rx_err stays set until the data port is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word: [0] flush, [1] handshake enable, [2] MSB first, [3] ninth bit enable, [4] parity enable, [5] parity sense / raw ninth bit, [6] two stop bits, [7] start level, [8] stop level |
| ctl_rdata | output | 9 | Control word readback, bit 0 always 0 |
| data_we | input | 1 | Data write strobe, queues a byte for sending |
| data_wdata | input | 8 | Byte to send |
| data_re | input | 1 | Data read strobe, clears the full state and rx_err |
| data_rdata | output | 8 | Last received byte |
| tx | output | 1 | Serial output |
| rx | input | 1 | Serial input (asynchronous) |
| cts | input | 1 | Peer ready to accept, active high |
| rts | output | 1 | Ready to accept, active high |
| rx_err | output | 1 | Sticky frame error flag |

## Verification
The bench builds the block with its defaults: eight data bits and sixteen ticks per bit. It drives one tick every four clocks, so a bit lasts 64 clocks. That period is short enough to run a few dozen full frames in both directions under every mix of start level, stop count, ninth-bit mode and bit order. It is also long enough to place flushes and short start pulses at chosen points inside a bit.

// File: rtl/uart_fe_pkg.sv
`timescale 1ns/1ps
package uart_fe_pkg;

    typedef struct packed {
        logic stop_lvl;
        logic start_lvl;
        logic two_stop;
        logic ninth_val;
        logic par_en;
        logic ninth_en;
        logic msb_first;
        logic flow_en;
    } fe_cfg_t;

    localparam int CFG_W = $bits(fe_cfg_t);
    localparam int CTL_W = CFG_W + 1;
    localparam fe_cfg_t CFG_RESET = fe_cfg_t'(8'h80);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP1, TX_STOP2
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP1, RX_STOP2
    } rx_state_t;

    // ninth bit: parity (even when ninth_val=1) or the raw ninth_val
    function automatic logic ninth_from(input logic ones_odd, input fe_cfg_t c);
        if (c.par_en)
            return c.ninth_val ? ones_odd : ~ones_odd;
        return c.ninth_val;
    endfunction

endpackage

// File: rtl/uart_fe_ctl.sv
`timescale 1ns/1ps
module uart_fe_ctl
    import uart_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output fe_cfg_t          cfg,
    output logic             flush,
    output logic [CTL_W-1:0] ctl_rdata
);
    fe_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (ctl_we)
            cfg_q <= fe_cfg_t'(ctl_wdata[CTL_W-1:1]);
    end

    always_comb begin
        cfg       = cfg_q;
        flush     = ctl_we & ctl_wdata[0];
        ctl_rdata = {cfg_q, 1'b0};
    end
endmodule

// File: rtl/uart_fe_tx.sv
`timescale 1ns/1ps
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              flush,
    input  logic              go,
    input  fe_cfg_t           cfg,
    input  logic [DATA_W-1:0] din,
    output logic              take,
    output logic              tx,
    output logic              idle
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(DATA_W - 1);

    tx_state_t         st, st_nx;
    logic [CNT_W-1:0]  ovs_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BIT_W-1:0]  idx;
    logic [DATA_W-1:0] sh_q;
    logic              ninth_q;
    logic              bit_end;

    assign bit_end = tick && (ovs_q == LAST_T);

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (go)      st_nx = TX_START;
            TX_START: if (bit_end) st_nx = TX_DATA;
            TX_DATA:  if (bit_end && bit_q == LAST_B)
                          st_nx = cfg.ninth_en ? TX_NINTH : TX_STOP1;
            TX_NINTH: if (bit_end) st_nx = TX_STOP1;
            TX_STOP1: if (bit_end) st_nx = cfg.two_stop ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (bit_end) st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
        if (flush)
            st_nx = TX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= TX_IDLE;
        else
            st <= st_nx;
    end

    assign take = (st == TX_IDLE) && go && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovs_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            ninth_q <= 1'b0;
        end else begin
            if (st == TX_IDLE || flush) begin
                ovs_q <= '0;
                bit_q <= '0;
            end else if (tick) begin
                ovs_q <= (ovs_q == LAST_T) ? '0 : ovs_q + CNT_W'(1);
                if (st == TX_DATA && ovs_q == LAST_T)
                    bit_q <= (bit_q == LAST_B) ? '0 : bit_q + BIT_W'(1);
            end
            if (take) begin
                sh_q    <= din;
                ninth_q <= ninth_from(^din, cfg);
            end
        end
    end

    always_comb begin
        idx  = cfg.msb_first ? (LAST_B - bit_q) : bit_q;
        idle = (st == TX_IDLE);
        unique case (st)
            TX_IDLE:            tx = ~cfg.start_lvl;
            TX_START:           tx = cfg.start_lvl;
            TX_DATA:            tx = sh_q[idx];
            TX_NINTH:           tx = ninth_q;
            TX_STOP1, TX_STOP2: tx = cfg.stop_lvl;
            default:            tx = ~cfg.start_lvl;
        endcase
    end
endmodule

// File: rtl/uart_fe_rx.sv
`timescale 1ns/1ps
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              flush,
    input  fe_cfg_t           cfg,
    input  logic              rx_in,
    output logic              done,
    output logic              frame_err,
    output logic [DATA_W-1:0] dout
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(DATA_W - 1);

    rx_state_t         st, st_nx;
    logic [CNT_W-1:0]  ovs_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_bad_q;
    logic              stop_bad_q;
    logic              bit_end;
    logic              mid_hit;
    logic              fin;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] dout_q;

    assign bit_end = tick && (ovs_q == LAST_T);
    assign mid_hit = tick && (ovs_q == MID_T);

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (tick && rx_in == cfg.start_lvl) st_nx = RX_START;
            RX_START: if (mid_hit)
                          st_nx = (rx_in == cfg.start_lvl) ? RX_DATA : RX_IDLE;
            RX_DATA:  if (bit_end && bit_q == LAST_B)
                          st_nx = cfg.ninth_en ? RX_NINTH : RX_STOP1;
            RX_NINTH: if (bit_end) st_nx = RX_STOP1;
            RX_STOP1: if (bit_end) st_nx = cfg.two_stop ? RX_STOP2 : RX_IDLE;
            RX_STOP2: if (bit_end) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
        if (flush)
            st_nx = RX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= RX_IDLE;
        else
            st <= st_nx;
    end

    assign fin = !flush && bit_end &&
                 ((st == RX_STOP1 && !cfg.two_stop) || st == RX_STOP2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovs_q      <= '0;
            bit_q      <= '0;
            sh_q       <= '0;
            par_bad_q  <= 1'b0;
            stop_bad_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            dout_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (st == RX_IDLE || flush || (st == RX_START && mid_hit)) begin
                ovs_q <= '0;
                bit_q <= '0;
            end else if (tick) begin
                ovs_q <= (ovs_q == LAST_T) ? '0 : ovs_q + CNT_W'(1);
            end
            if (st == RX_START && mid_hit) begin
                par_bad_q  <= 1'b0;
                stop_bad_q <= 1'b0;
            end
            if (!flush && bit_end) begin
                unique case (st)
                    RX_DATA: begin
                        sh_q  <= cfg.msb_first ? {sh_q[DATA_W-2:0], rx_in}
                                               : {rx_in, sh_q[DATA_W-1:1]};
                        bit_q <= (bit_q == LAST_B) ? '0 : bit_q + BIT_W'(1);
                    end
                    RX_NINTH:
                        par_bad_q <= cfg.par_en && (rx_in != ninth_from(^sh_q, cfg));
                    RX_STOP1:
                        stop_bad_q <= (rx_in != cfg.stop_lvl);
                    default: ;
                endcase
            end
            if (fin) begin
                done_q <= 1'b1;
                err_q  <= par_bad_q | (cfg.two_stop & stop_bad_q) |
                          (rx_in != cfg.stop_lvl);
                dout_q <= sh_q;
            end
        end
    end

    assign done      = done_q;
    assign frame_err = err_q;
    assign dout      = dout_q;
endmodule

// File: rtl/uart_frame_engine.sv
`timescale 1ns/1ps
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              data_re,
    output logic [DATA_W-1:0] data_rdata,
    output logic              tx,
    input  logic              rx,
    input  logic              cts,
    output logic              rts,
    output logic              rx_err
);
    fe_cfg_t           cfg;
    logic              flush;
    logic              tx_go;
    logic              tx_take;
    logic              tx_idle;
    logic              rx_done;
    logic              rx_ferr;
    logic [DATA_W-1:0] rx_byte;
    logic [1:0]        rx_sync_q;
    logic [DATA_W-1:0] hold_q;
    logic              pend_q;
    logic [DATA_W-1:0] rdata_q;
    logic              full_q;
    logic              err_q;

    uart_fe_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .cfg       (cfg),
        .flush     (flush),
        .ctl_rdata (ctl_rdata)
    );

    assign tx_go = pend_q && (!cfg.flow_en || cts);

    uart_fe_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .flush (flush),
        .go    (tx_go),
        .cfg   (cfg),
        .din   (hold_q),
        .take  (tx_take),
        .tx    (tx),
        .idle  (tx_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sync_q <= {2{~CFG_RESET.start_lvl}};
        else
            rx_sync_q <= {rx_sync_q[0], rx};
    end

    uart_fe_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .flush     (flush),
        .cfg       (cfg),
        .rx_in     (rx_sync_q[1]),
        .done      (rx_done),
        .frame_err (rx_ferr),
        .dout      (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            pend_q  <= 1'b0;
            rdata_q <= '0;
            full_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (data_we)
                hold_q <= data_wdata;
            if (flush)
                pend_q <= 1'b0;
            else if (data_we)
                pend_q <= 1'b1;
            else if (tx_take)
                pend_q <= 1'b0;
            if (rx_done) begin
                rdata_q <= rx_byte;
                full_q  <= 1'b1;
            end else if (data_re) begin
                full_q  <= 1'b0;
            end
            if (rx_done && rx_ferr)
                err_q <= 1'b1;
            else if (data_re)
                err_q <= 1'b0;
        end
    end

    assign data_rdata = rdata_q;
    assign rts        = cfg.flow_en ? ~full_q : 1'b1;
    assign rx_err     = err_q;
endmodule

// File: rtl/uart_frame_engine_chk.sv
`timescale 1ns/1ps
module uart_frame_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [8:0] ctl_wdata,
    input logic [8:0] ctl_rdata,
    input logic       tx,
    input logic       tx_idle,
    input logic       cts,
    input logic       rts,
    input logic       rx_err,
    input logic       rx_done,
    input logic       data_re
);
    // R2
    start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && $past(tx_idle)) |-> (tx == ctl_rdata[7]));

    // R10
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[0]) |=> (tx_idle && tx != ctl_rdata[7]));

    // R8
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1] && !cts && tx_idle) |=> tx_idle);

    // R9
    rts_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[1] |-> rts);

    // R9
    rts_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1] && rx_done && !ctl_we) |=> !rts);

    // R13
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_err) |-> $past(rx_done));

    // R13
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && data_re && !rx_done) |=> !rx_err);
endmodule

bind uart_frame_engine uart_frame_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .tx        (tx),
    .tx_idle   (tx_idle),
    .cts       (cts),
    .rts       (rts),
    .rx_err    (rx_err),
    .rx_done   (rx_done),
    .data_re   (data_re)
);

// File: tb/uart_frame_engine_bench.sv
`timescale 1ns/1ps
module uart_frame_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       ctl_we = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic [8:0] ctl_rdata;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       data_re = 1'b0;
    logic [7:0] data_rdata;
    logic       tx;
    logic       rx = 1'b1;
    logic       cts = 1'b0;
    logic       rts;
    logic       rx_err;

    int checks = 0;
    int errs = 0;
    bit finished = 0;

    uart_frame_engine u_uart_frame_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .data_re    (data_re),
        .data_rdata (data_rdata),
        .tx         (tx),
        .rx         (rx),
        .cts        (cts),
        .rts        (rts),
        .rx_err     (rx_err)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    function automatic logic [8:0] cw(input logic st, input logic two, input logic nin,
                                      input logic par, input logic nv, input logic msb,
                                      input logic flow);
        return {~st, st, two, nv, par, nin, msb, flow, 1'b0};
    endfunction

    // expected line bits of one frame, first bit in [0]
    function automatic int frame_bits(input logic [8:0] c, input logic [7:0] d,
                                      output logic [11:0] b);
        int n;
        b = '0;
        b[0] = c[7];
        n = 1;
        for (int i = 0; i < 8; i++) begin
            b[n] = c[2] ? d[7-i] : d[i];
            n = n + 1;
        end
        if (c[3]) begin
            b[n] = c[4] ? (c[5] ? ^d : ~^d) : c[5];
            n = n + 1;
        end
        b[n] = c[8];
        n = n + 1;
        if (c[6]) begin
            b[n] = c[8];
            n = n + 1;
        end
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [8:0] w);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [8:0] c);
        ctl_write(c);
        rx = ~c[7];
        repeat (10) @(negedge clk);
        ctl_write(c | 9'h001);
    endtask

    task automatic data_write(input logic [7:0] d);
        @(negedge clk);
        data_we = 1'b1;
        data_wdata = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic read_data();
        @(negedge clk);
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
    endtask

    task automatic tx_capture(input int n, input logic lvl, output logic [11:0] got,
                              output bit found);
        got = '0;
        found = 0;
        for (int i = 0; i < 4000 && !found; i++) begin
            @(negedge clk);
            if (tx == lvl) found = 1;
        end
        if (found) begin
            repeat (32) @(negedge clk);
            got[0] = tx;
            for (int i = 1; i < n; i++) begin
                repeat (64) @(negedge clk);
                got[i] = tx;
            end
            repeat (48) @(negedge clk);
        end
    endtask

    task automatic tx_frame_test(input logic [8:0] c, input logic [7:0] d,
                                 input string req);
        logic [11:0] exp;
        logic [11:0] got;
        int n;
        bit found;
        n = frame_bits(c, d, exp);
        data_write(d);
        tx_capture(n, c[7], got, found);
        chk(found && got == exp, req, {20'd0, got}, {20'd0, exp});
    endtask

    task automatic rx_send(input logic [11:0] b, input int n, input logic idle_lvl);
        for (int i = 0; i < n; i++) begin
            rx = b[i];
            repeat (64) @(negedge clk);
        end
        rx = idle_lvl;
        repeat (24) @(negedge clk);
    endtask

    task automatic rx_frame_test(input logic [8:0] c, input logic [7:0] d, input int flip,
                                 input bit exp_err, input string req);
        logic [11:0] b;
        int n;
        set_cfg(c);
        n = frame_bits(c, d, b);
        if (flip >= 0) b[flip] = ~b[flip];
        rx_send(b, n, ~c[7]);
        // R11 received byte on the data port
        chk(data_rdata == d, {"R11 rx data ", req}, {24'd0, data_rdata}, {24'd0, d});
        // R13 sticky error value
        chk(rx_err == exp_err, {"R13 rx_err ", req}, {31'd0, rx_err}, {31'd0, exp_err});
        read_data();
        chk(rx_err == 1'b0, "R13 rx_err cleared by read", {31'd0, rx_err}, 32'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        logic [8:0]  c;
        logic [11:0] got;
        logic [11:0] exp;
        int          lows;
        int          n;
        int          flip;
        bit          e;
        bit          found;

        r = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctl_rdata == 9'h100, "R1 ctl reset", {23'd0, ctl_rdata}, 32'h100);
        chk(tx == 1'b1, "R1 tx idle high", {31'd0, tx}, 32'd1);
        chk(rts == 1'b1, "R1 rts high", {31'd0, rts}, 32'd1);
        chk(rx_err == 1'b0, "R1 rx_err low", {31'd0, rx_err}, 32'd0);
        chk(data_rdata == 8'h00, "R1 data zero", {24'd0, data_rdata}, 32'd0);

        // directed transmit frames
        set_cfg(cw(0, 0, 0, 0, 0, 0, 0));
        tx_frame_test(cw(0, 0, 0, 0, 0, 0, 0), 8'hA5, "R4 plain 8-bit frame");
        set_cfg(cw(0, 0, 1, 1, 1, 0, 0));
        tx_frame_test(cw(0, 0, 1, 1, 1, 0, 0), 8'h01, "R5 even parity");
        set_cfg(cw(0, 0, 1, 1, 0, 0, 0));
        tx_frame_test(cw(0, 0, 1, 1, 0, 0, 0), 8'h01, "R5 odd parity");
        set_cfg(cw(0, 0, 1, 0, 1, 0, 0));
        tx_frame_test(cw(0, 0, 1, 0, 1, 0, 0), 8'h03, "R6 raw ninth bit");
        set_cfg(cw(0, 0, 0, 0, 0, 1, 0));
        tx_frame_test(cw(0, 0, 0, 0, 0, 1, 0), 8'h01, "R7 msb first");
        set_cfg(cw(1, 1, 0, 0, 0, 0, 0));
        @(negedge clk);
        chk(tx == 1'b0, "R2 idle low with high start", {31'd0, tx}, 32'd0);
        tx_frame_test(cw(1, 1, 0, 0, 0, 0, 0), 8'h5C, "R2 R3 high start two stops");

        // random transmit frames
        for (int k = 0; k < 20; k++) begin
            r  = $urandom;
            r2 = $urandom;
            c  = cw(r[0], r[1], r[2], r[3], r[4], r[5], 1'b0);
            set_cfg(c);
            tx_frame_test(c, (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : r2[7:0],
                          "R2/R3/R4/R5/R6/R7 random tx frame");
        end

        // R10 flush mid-frame on transmit
        set_cfg(cw(0, 0, 0, 0, 0, 0, 0));
        data_write(8'h00);
        repeat (200) @(negedge clk);
        chk(tx == 1'b0, "R10 frame in progress", {31'd0, tx}, 32'd0);
        ctl_write(cw(0, 0, 0, 0, 0, 0, 0) | 9'h001);
        chk(tx == 1'b1, "R10 flush idles tx", {31'd0, tx}, 32'd1);
        chk(ctl_rdata == cw(0, 0, 0, 0, 0, 0, 0), "R10 flush reads zero",
            {23'd0, ctl_rdata}, {23'd0, cw(0, 0, 0, 0, 0, 0, 0)});
        lows = 0;
        repeat (1500) begin
            @(negedge clk);
            if (tx == 1'b0) lows++;
        end
        chk(lows == 0, "R10 no frame after flush", lows, 0);

        // R8 CTS gating
        set_cfg(cw(0, 0, 0, 0, 0, 0, 1));
        cts = 1'b0;
        data_write(8'h5A);
        lows = 0;
        repeat (1000) begin
            @(negedge clk);
            if (tx == 1'b0) lows++;
        end
        chk(lows == 0, "R8 cts low holds frame", lows, 0);
        cts = 1'b1;
        n = frame_bits(cw(0, 0, 0, 0, 0, 0, 1), 8'h5A, exp);
        tx_capture(n, 1'b0, got, found);
        chk(found && got == exp, "R8 cts high releases frame", {20'd0, got}, {20'd0, exp});
        set_cfg(cw(0, 0, 0, 0, 0, 0, 0));
        cts = 1'b0;
        tx_frame_test(cw(0, 0, 0, 0, 0, 0, 0), 8'hC3, "R8 cts ignored without flow");

        // directed receive frames
        rx_frame_test(cw(0, 0, 0, 0, 0, 0, 0), 8'h96, -1, 1'b0, "plain");
        rx_frame_test(cw(0, 0, 1, 1, 1, 1, 0), 8'h07, -1, 1'b0, "R7 msb even parity");
        rx_frame_test(cw(0, 0, 1, 1, 1, 0, 0), 8'h07, 9, 1'b1, "parity mismatch");
        rx_frame_test(cw(0, 0, 0, 0, 0, 0, 0), 8'h21, 9, 1'b1, "bad stop level");
        rx_frame_test(cw(1, 1, 0, 0, 0, 0, 0), 8'h42, 10, 1'b1, "R3 bad second stop");
        rx_frame_test(cw(0, 0, 1, 0, 0, 0, 0), 8'h3E, 9, 1'b0, "R6 raw ninth no error");

        // random receive frames
        for (int k = 0; k < 20; k++) begin
            r  = $urandom;
            r2 = $urandom;
            c  = cw(r[0], r[1], r[2], r[3], r[4], r[5], 1'b0);
            flip = -1;
            e = 1'b0;
            if (r[7:6] == 2'd0 && c[3]) begin
                flip = 9;
                e = c[4];
            end else if (r[7:6] == 2'd1) begin
                flip = c[3] ? 10 : 9;
                e = 1'b1;
            end
            rx_frame_test(c, r2[7:0], flip, e, "random");
        end

        // R9 RTS handshake
        set_cfg(cw(0, 0, 0, 0, 0, 0, 1));
        @(negedge clk);
        chk(rts == 1'b1, "R9 rts high while empty", {31'd0, rts}, 32'd1);
        n = frame_bits(cw(0, 0, 0, 0, 0, 0, 1), 8'h3C, exp);
        rx_send(exp, n, 1'b1);
        chk(rts == 1'b0, "R9 rts low when full", {31'd0, rts}, 32'd0);
        chk(data_rdata == 8'h3C, "R11 rx data with flow", {24'd0, data_rdata}, 32'h3C);
        read_data();
        chk(rts == 1'b1, "R9 rts high after read", {31'd0, rts}, 32'd1);
        set_cfg(cw(0, 0, 0, 0, 0, 0, 0));
        n = frame_bits(cw(0, 0, 0, 0, 0, 0, 0), 8'h11, exp);
        rx_send(exp, n, 1'b1);
        chk(rts == 1'b1, "R9 rts high without flow", {31'd0, rts}, 32'd1);
        read_data();

        // R12 short start pulse rejected
        set_cfg(cw(0, 0, 0, 0, 0, 0, 1));
        rx = 1'b0;
        repeat (12) @(negedge clk);
        rx = 1'b1;
        repeat (1500) @(negedge clk);
        chk(rts == 1'b1, "R12 no frame from glitch", {31'd0, rts}, 32'd1);
        chk(data_rdata == 8'h11, "R12 data kept", {24'd0, data_rdata}, 32'h11);
        chk(rx_err == 1'b0, "R12 no error from glitch", {31'd0, rx_err}, 32'd0);

        // R10 flush mid-frame on receive
        rx = 1'b0;
        repeat (160) @(negedge clk);
        rx = 1'b1;
        ctl_write(cw(0, 0, 0, 0, 0, 0, 1) | 9'h001);
        repeat (1500) @(negedge clk);
        chk(rts == 1'b1, "R10 rx flush drops frame", {31'd0, rts}, 32'd1);
        chk(data_rdata == 8'h11, "R10 rx flush keeps data", {24'd0, data_rdata}, 32'h11);

        finished = 1;
        summary();
        $finish;
    end
endmodule